// File: doc/BRIEF.md
# Four-Channel Two-Stage PWM Generator

This block produces four independent pulse-width-modulated outputs from one input clock. Every channel divides the clock in two cascaded stages: a prescaler turns the input clock into ticks, and a period divider counts those ticks to form one output period. A high-duration count, also measured in ticks, sets how long the output stays high at the start of each period.

Software programs the channels through a small 32-bit register port with separate write and read strobes. Divider and duty values are first held in staging registers. They reach the running counters only when a write carries the commit flag. While a channel runs, a committed change waits for the end of the current period, so no shortened or distorted period appears on the pin. An idle channel takes the change at once. Each channel has its own run flag, and a stopped channel drives low with its counters cleared. Only active-high output is supported.

Top module: `pwm_bank`

## Requirements
- R1: Channel c owns two word registers at byte address 8*c (word A) and 8*c+4 (word B). Word A holds the period divider in bits [15:0] and the high count in bits [31:16]. Word B holds the prescaler in bits [15:0], the commit flag in bit 30 and the run flag in bit 31. Reads return staged values in `rdata` on the cycle after `rd_en`. Accesses with address bits [1:0] not zero are ignored, and such reads return zero.
- R2: In a read of word B, bits [30:16] are zero: the commit flag always reads back as zero.
- R3: While a channel runs, its output period is (prescaler+1)*(divider+1) input clock cycles.
- R4: The output is high for high*(prescaler+1) cycles at the start of every period and low for the rest of it.
- R5: A high count of at least divider+1 holds the output high for the whole period.
- R6: A high count of zero holds the output low.
- R7: Writes that do not set the commit flag change only the staged values. The running output keeps its period and high time.
- R8: A commit issued while the channel runs takes effect at the next period boundary. The period in progress completes with the old settings, and the next period uses the new ones.
- R9: A commit issued while the channel is stopped takes effect at once. This includes a commit in the same write that sets the run flag, so the first period already uses the new settings.
- R10: A channel whose run flag is clear drives low from the second cycle after the write. Its counters are cleared, so setting the run flag again starts a full period. After reset all outputs are low and every register reads zero.
- R11: Channels run independently, each with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, which also drives the counters |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pwm_out | output | 4 | PWM outputs, one per channel |

## Verification
The bench issues a commit on the rising edge of a period and measures that pulse and the next one. A design that loads the new settings straight away would cut the current period short or stretch it, and that breaks R8. It re-enables a stopped channel without a commit and checks that the first period has full length, which exposes counters left frozen part-way through a period. Random settings cover the cases of a high count of zero and of a high count of at least divider+1, where an off-by-one comparison would let through a stray one-tick pulse or a one-tick gap. The bench also checks that unaligned writes leave the registers unchanged, that the commit flag reads back as zero, and that staged writes do not reach a running channel until a commit.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  parameter int unsigned PB_CNT_W  = 16;
  parameter int unsigned PB_DATA_W = 32;
  localparam int unsigned PB_CMT_BIT = 30;
  localparam int unsigned PB_RUN_BIT = 31;
  localparam int unsigned PB_PAD_W   = PB_DATA_W - PB_CNT_W - 2;

  typedef logic [PB_CNT_W-1:0] pb_cnt_t;

  typedef struct packed {
    pb_cnt_t hi;
    pb_cnt_t div;
    pb_cnt_t pre;
  } pb_cfg_t;

  // true when a counter sits on its terminal value
  function automatic logic pb_last(pb_cnt_t c, pb_cnt_t lim);
    return c == lim;
  endfunction

  // next value of a wrapping counter
  function automatic pb_cnt_t pb_step(pb_cnt_t c, pb_cnt_t lim);
    return pb_last(c, lim) ? '0 : c + 1'b1;
  endfunction

  // output level for a given tick position inside the period
  function automatic logic pb_level(pb_cnt_t pos, pb_cnt_t hi);
    return pos < hi;
  endfunction

  function automatic logic [PB_DATA_W-1:0] pb_word_a(pb_cfg_t c);
    return {c.hi, c.div};
  endfunction

  function automatic logic [PB_DATA_W-1:0] pb_word_b(pb_cfg_t c, logic run);
    return {run, 1'b0, {PB_PAD_W{1'b0}}, c.pre};
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [PB_DATA_W-1:0]     wdata,
  output logic [PB_DATA_W-1:0]     rdata,
  output pb_cfg_t [NCH-1:0]        stg,
  output logic [NCH-1:0]           run_flag,
  output logic [NCH-1:0]           commit
);

  localparam int CH_W = ADDR_W - 3;

  logic [CH_W-1:0]      a_ch;
  logic                 aligned;
  logic                 ch_ok;
  logic [PB_DATA_W-1:0] rd_word;

  assign a_ch    = addr[ADDR_W-1:3];
  assign aligned = (addr[1:0] == 2'b00);
  assign ch_ok   = (int'(a_ch) < NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    logic hit_a;
    logic hit_b;
    assign hit_a = wr_en && aligned && (a_ch == CH_W'(i)) && !addr[2];
    assign hit_b = wr_en && aligned && (a_ch == CH_W'(i)) &&  addr[2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[i]      <= '0;
        run_flag[i] <= 1'b0;
        commit[i]   <= 1'b0;
      end else begin
        commit[i] <= hit_b && wdata[PB_CMT_BIT];
        if (hit_a) begin
          stg[i].div <= wdata[PB_CNT_W-1:0];
          stg[i].hi  <= wdata[PB_DATA_W-1:PB_CNT_W];
        end
        if (hit_b) begin
          stg[i].pre  <= wdata[PB_CNT_W-1:0];
          run_flag[i] <= wdata[PB_RUN_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (aligned && ch_ok) begin
      rd_word = addr[2] ? pb_word_b(stg[a_ch], run_flag[a_ch])
                        : pb_word_a(stg[a_ch]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_flag,
  input  logic    commit,
  input  pb_cfg_t stg,
  output logic    pwm,
  output logic    running,
  output logic    bnd,
  output pb_cfg_t act,
  output pb_cnt_t pre_cnt,
  output pb_cnt_t div_cnt
);

  pb_cfg_t pend;
  logic    pend_v;
  logic    tick;

  // one prescaled tick ends when the prescaler wraps
  assign tick = running && pb_last(pre_cnt, act.pre);
  // a period ends when both stages wrap together
  assign bnd  = tick && pb_last(div_cnt, act.div);
  assign pwm  = running && pb_level(div_cnt, act.hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      act     <= '0;
      pend    <= '0;
      pend_v  <= 1'b0;
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      running <= run_flag;
      if (!running) begin
        pre_cnt <= '0;
        div_cnt <= '0;
        pend_v  <= 1'b0;
        if (commit)      act <= stg;
        else if (pend_v) act <= pend;
      end else begin
        pre_cnt <= pb_step(pre_cnt, act.pre);
        if (tick) div_cnt <= pb_step(div_cnt, act.div);
        if (bnd) begin
          pend_v <= 1'b0;
          if (commit)      act <= stg;
          else if (pend_v) act <= pend;
        end else if (commit) begin
          pend   <= stg;
          pend_v <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter  int NCH    = 4,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PB_DATA_W-1:0] wdata,
  output logic [PB_DATA_W-1:0] rdata,
  output logic [NCH-1:0]       pwm_out
);

  pb_cfg_t [NCH-1:0]           stg;
  logic    [NCH-1:0]           ch_en;
  logic    [NCH-1:0]           ch_commit;
  logic    [NCH-1:0]           ch_run;
  logic    [NCH-1:0]           ch_bnd;
  pb_cfg_t [NCH-1:0]           ch_act;
  logic    [NCH-1:0][PB_CNT_W-1:0] ch_pre_cnt;
  logic    [NCH-1:0][PB_CNT_W-1:0] ch_div_cnt;

  pwm_bank_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .stg      (stg),
    .run_flag (ch_en),
    .commit   (ch_commit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_bank_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_flag (ch_en[i]),
      .commit   (ch_commit[i]),
      .stg      (stg[i]),
      .pwm      (pwm_out[i]),
      .running  (ch_run[i]),
      .bnd      (ch_bnd[i]),
      .act      (ch_act[i]),
      .pre_cnt  (ch_pre_cnt[i]),
      .div_cnt  (ch_div_cnt[i])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_en,
  input logic                         rd_sel_b,
  input logic [14:0]                  rd_mid,
  input logic [NCH-1:0]               pwm_out,
  input logic [NCH-1:0]               ch_en,
  input logic [NCH-1:0]               ch_run,
  input logic [NCH-1:0]               ch_bnd,
  input pb_cfg_t [NCH-1:0]            ch_act,
  input logic [NCH-1:0][PB_CNT_W-1:0] ch_pre_cnt,
  input logic [NCH-1:0][PB_CNT_W-1:0] ch_div_cnt
);

  AST_CMT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && rd_sel_b) |-> (rd_mid == 15'd0)); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> !pwm_out[i]); // R10

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[i] |-> (ch_pre_cnt[i] <= ch_act[i].pre)); // R3

    AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[i] |-> (ch_div_cnt[i] <= ch_act[i].div)); // R3

    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_act[i] != $past(ch_act[i])) |-> ($past(ch_bnd[i]) || !$past(ch_run[i]))); // R8
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_sel_b   (addr[2]),
  .rd_mid     (rdata[30:16]),
  .pwm_out    (pwm_out),
  .ch_en      (ch_en),
  .ch_run     (ch_run),
  .ch_bnd     (ch_bnd),
  .ch_act     (ch_act),
  .ch_pre_cnt (ch_pre_cnt),
  .ch_div_cnt (ch_div_cnt)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/100ps
module pwm_bank_test;

  localparam int NCH = 4;
  localparam int AW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // edge monitor on one selected channel
  int mon_ch = 0;
  int cyc = 0, nrise = 0, rise_t = 0, nhigh = 0, nsamp = 0;
  bit prev = 0, cur = 0;
  int per_q [16];
  int hi_q  [16];

  always @(negedge clk) begin
    cur = pwm_out[mon_ch];
    cyc++;
    if (cur && !prev) begin
      if (nrise > 0 && nrise <= 16) per_q[nrise-1] = cyc - rise_t;
      rise_t = cyc;
      nrise++;
    end
    if (!cur && prev && nrise > 0 && nrise <= 16) hi_q[nrise-1] = cyc - rise_t;
    if (cur) nhigh++;
    nsamp++;
    prev = cur;
  end

  function automatic int exp_period(int pre, int dv);
    return (pre + 1) * (dv + 1);
  endfunction

  function automatic int exp_high(int pre, int hi);
    return hi * (pre + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic mon_clear(int ch);
    mon_ch = ch;
    nrise = 0; nhigh = 0; nsamp = 0;
    prev = pwm_out[ch];
    for (int k = 0; k < 16; k++) begin per_q[k] = -1; hi_q[k] = -1; end
  endtask

  task automatic bus_wr(int ch, bit sel_b, logic [31:0] d, int off = 0);
    wr_en = 1'b1;
    addr  = AW'(ch * 8 + (sel_b ? 4 : 0) + off);
    wdata = d;
    @(posedge clk);
    @(negedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(int ch, bit sel_b, output logic [31:0] d);
    rd_en = 1'b1;
    addr  = AW'(ch * 8 + (sel_b ? 4 : 0));
    @(posedge clk);
    @(negedge clk);
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] word_a(int hi, int dv);
    return {hi[15:0], dv[15:0]};
  endfunction

  // word B: bit31 run, bit30 commit, [15:0] prescaler
  function automatic logic [31:0] word_b(bit run, bit cmt, int pre);
    return {run, cmt, 14'd0, pre[15:0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_2024));
    step(3);
    rst_n = 1'b1;
    step(2);

    // R10 reset state
    check("R10 reset outputs", int'(pwm_out), 0);
    bus_rd(1, 1'b1, rd);
    check("R10 reset word B", int'(rd), 0);

    // R1 register map and readback, R2 commit flag reads zero
    bus_wr(2, 1'b0, 32'h00A5_0007);
    bus_wr(2, 1'b1, word_b(0, 1, 3));
    bus_rd(2, 1'b0, rd);
    check("R1 word A readback", int'(rd), int'(32'h00A5_0007));
    bus_rd(2, 1'b1, rd);
    check("R2 commit reads zero", int'(rd), 3);
    bus_wr(2, 1'b1, 32'hFFFF_0003);
    bus_rd(2, 1'b1, rd);
    check("R2 middle bits zero", int'(rd), int'(32'h8000_0003));
    bus_wr(3, 1'b0, 32'hFFFF_FFFF, 1);
    bus_rd(3, 1'b0, rd);
    check("R1 unaligned write ignored", int'(rd), 0);

    // R9 commit while stopped, same write as run: pre=1 div=4 hi=2
    mon_clear(0);
    bus_wr(0, 1'b0, word_a(2, 4));
    bus_wr(0, 1'b1, word_b(1, 1, 1));
    step(30);
    check("R9 first period R3", per_q[0], exp_period(1, 4));
    check("R9 first high R4", hi_q[0], exp_high(1, 2));

    // R7 staged write without commit keeps output
    bus_wr(0, 1'b0, word_a(3, 7));
    mon_clear(0);
    step(30);
    check("R7 period unchanged", per_q[1], exp_period(1, 4));
    check("R7 high unchanged", hi_q[1], exp_high(1, 2));

    // R8 commit inside a period completes it first
    mon_clear(0);
    while (nrise < 1) step(1);
    bus_wr(0, 1'b1, word_b(1, 1, 1));
    step(45);
    check("R8 old high", hi_q[0], exp_high(1, 2));
    check("R8 old period", per_q[0], exp_period(1, 4));
    check("R8 new high", hi_q[1], exp_high(1, 3));
    check("R8 new period", per_q[1], exp_period(1, 7));

    // R10 stop drives low, restart gives a full period
    bus_wr(0, 1'b1, word_b(0, 0, 1));
    step(2);
    mon_clear(0);
    step(20);
    check("R10 stopped low", nhigh, 0);
    mon_clear(0);
    bus_wr(0, 1'b1, word_b(1, 0, 1));
    step(40);
    check("R10 restart full period", per_q[0], exp_period(1, 7));
    check("R10 restart full high", hi_q[0], exp_high(1, 3));

    // R5 full duty, R6 zero duty on channel 1
    bus_wr(1, 1'b0, word_a(4, 3));
    bus_wr(1, 1'b1, word_b(1, 1, 2));
    step(4);
    mon_clear(1);
    step(60);
    check("R5 always high", nhigh, nsamp);
    bus_wr(1, 1'b0, word_a(0, 3));
    bus_wr(1, 1'b1, word_b(1, 1, 2));
    step(20);
    mon_clear(1);
    step(40);
    check("R6 always low", nhigh, 0);

    // R11 two channels with different settings
    bus_wr(2, 1'b0, word_a(2, 5));
    bus_wr(2, 1'b1, word_b(1, 1, 0));
    bus_wr(3, 1'b0, word_a(1, 2));
    bus_wr(3, 1'b1, word_b(1, 1, 2));
    step(10);
    mon_clear(2);
    step(40);
    check("R11 ch2 period", per_q[1], exp_period(0, 5));
    check("R11 ch2 high", hi_q[1], exp_high(0, 2));
    mon_clear(3);
    step(40);
    check("R11 ch3 period", per_q[1], exp_period(2, 2));
    check("R11 ch3 high", hi_q[1], exp_high(2, 1));

    // random settings: R3 R4 R5 R6
    for (int it = 0; it < 24; it++) begin
      int ch, pre, dv, hi, r, p;
      ch  = $urandom_range(0, NCH - 1);
      pre = $urandom_range(0, 3);
      dv  = $urandom_range(1, 9);
      r   = $urandom_range(0, 9);
      hi  = (r == 0) ? 0 : (r == 1) ? dv + 1 : $urandom_range(1, dv);
      p   = exp_period(pre, dv);
      bus_wr(ch, 1'b1, word_b(0, 0, pre));
      step(2);
      bus_wr(ch, 1'b0, word_a(hi, dv));
      mon_clear(ch);
      bus_wr(ch, 1'b1, word_b(1, 1, pre));
      if (hi == 0 || hi > dv) begin
        step(3);
        mon_clear(ch);
        step(2 * p + 4);
        if (hi == 0) check("R6 random low", nhigh, 0);
        else check("R5 random high", nhigh, nsamp);
      end else begin
        step(3 * p + 6);
        check("R3 random period", per_q[1], p);
        check("R4 random high", hi_q[1], exp_high(pre, hi));
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule